// File: doc/BRIEF.md
# Sub-word Load/Store Lane Unit

This block connects a 64-bit load/store datapath to a 64-bit-wide, little-endian, byte-addressed data memory. On a load, it takes the memory word or words that hold the requested bytes and picks those bytes out. It then widens the result to 64 bits, with either sign extension or zero extension. On a store, it moves the low bytes of the source operand into their byte lanes and builds the matching byte-enable mask. It handles byte, halfword, word and doubleword accesses at any byte address.

An access can run past the end of a 64-bit memory word. In that case the unit issues two memory beats, one to each word, and joins the two halves. The requester sees this through a ready signal, which stays low from acceptance until the response. The memory port issues at most one beat per cycle, and read data returns one cycle after the beat.

Top module: `lsu_lane_unit`

## Requirements
- R1: In the first cycle after reset, `req_ready` is 1, `mem_valid` is 0 and `rsp_valid` is 0.
- R2: The memory is little endian. The byte at address A is bits [8*k+7:8*k] of memory word A>>3, where k = A[2:0]. A multi-byte value has its least-significant byte at its lowest address.
- R3: Signed loads (`req_unsigned`=0) of a byte (`req_size`=0), a halfword (1) or a word (2) sign-extend the value to 64 bits from its top bit.
- R4: Unsigned loads (`req_unsigned`=1) of a byte, a halfword or a word zero-extend the value to 64 bits.
- R5: A doubleword access (`req_size`=3) moves all 64 bits, and `req_unsigned` has no effect on it.
- R6: A store of N bytes (N = 1 << `req_size`) writes only the low N bytes of `req_wdata`. The first beat's `mem_be` is bits [7:0] of the 16-bit mask ((1<<N)-1) << A[2:0]. `mem_wdata` holds the operand bytes in those lanes and zero in every other lane.
- R7: When A[2:0] + N > 8, a second beat follows in the next cycle. It goes to word (A>>3)+1, and its `mem_be` is bits [15:8] of the same mask.
- R8: `req_ready` is 1 only while idle, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is high for exactly one cycle: the cycle after acceptance for a single-beat access, or the second cycle after acceptance for a two-beat access.
- R9: A two-beat load returns the high bytes of the first word joined with the low bytes of the second word.
- R10: `mem_we` is 1 on the beats of a store and 0 on the beats of a load. A store's response carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | log2 of access bytes: 0 byte, 1 half, 2 word, 3 double |
| req_unsigned | input | 1 | Zero-extend a load instead of sign-extend |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store operand |
| mem_valid | output | 1 | Memory beat issued this cycle |
| mem_we | output | 1 | Beat is a write |
| mem_word | output | ADDR_W-3 | Memory word index |
| mem_be | output | 8 | Byte enables for a write beat |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_rdata | input | 64 | Read data, one cycle after a read beat |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | 64 | Extended load result |

## Verification
The hardest case to reach from the ports is a two-beat access in which the two halves come from different memory words. This includes the case where the second word index wraps around the top of the memory model. The stimulus creates it with stores at offsets such as 6 and 7. These place known bytes on both sides of a word boundary, and loads of every size then read back across that boundary, including at the final word of memory. A scoreboard keeps a byte-level copy of memory, and it predicts every load and every lane mask from that copy.

// File: rtl/lsu_pkg.sv
// Shared types for the load/store lane unit.
// Assumes the datapath is 64 bits wide and that access sizes are powers of two.
package lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SECOND = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lsu_store_steer.sv
// Store lane steering: turns size and offset into a two-word byte-enable pair.
// It also shifts the kept operand bytes into their lanes across both words.
// Assumes off + size never exceeds two words, which holds for sizes up to DATA_W.
module lsu_store_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NB    = DATA_W / 8,
    localparam int OFFW  = $clog2(NB)
) (
    input  acc_size_e           size,
    input  logic [OFFW-1:0]     off,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*NB-1:0]     be_pair,
    output logic [2*DATA_W-1:0] data_pair
);
    logic [OFFW:0]       nbytes;
    logic [2*NB-1:0]     low_mask;
    logic [DATA_W-1:0]   kept;

    // Build the unshifted mask and drop operand bytes above the access size.
    always_comb begin
        nbytes   = (OFFW+1)'(1) << size;
        low_mask = '0;
        kept     = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < int'(nbytes)) begin
                low_mask[i]  = 1'b1;
                kept[8*i +: 8] = wdata[8*i +: 8];
            end
        end
    end

    // Shift the mask and the data to the byte offset.
    always_comb begin
        be_pair   = low_mask << off;
        data_pair = {{DATA_W{1'b0}}, kept} << {off, 3'b000};
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load lane extraction: shifts a two-word window down by the byte offset.
// It then extends the selected bytes to the full width.
// Assumes the low word of the pair is the word addressed first.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NB    = DATA_W / 8,
    localparam int OFFW  = $clog2(NB)
) (
    input  logic [2*DATA_W-1:0] pair,
    input  logic [OFFW-1:0]     off,
    input  acc_size_e           size,
    input  logic                uns,
    output logic [DATA_W-1:0]   value
);
    logic [2*DATA_W-1:0] shifted;
    logic [DATA_W-1:0]   win;

    // Align the wanted bytes to bit 0.
    always_comb begin
        shifted = pair >> {off, 3'b000};
        win     = shifted[DATA_W-1:0];
    end

    // Apply the sign or zero extension that the size calls for.
    always_comb begin
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-8){~uns & win[7]}},   win[7:0]};
            SZ_HALF: value = {{(DATA_W-16){~uns & win[15]}}, win[15:0]};
            SZ_WORD: value = {{(DATA_W-32){~uns & win[31]}}, win[31:0]};
            default: value = win;
        endcase
    end
endmodule

// File: rtl/lsu_seq_ctrl.sv
// Beat sequencer: idle -> (second beat) -> finish -> idle.
// It holds the first read word while the second beat is in flight.
// Assumes memory returns read data one cycle after each beat.
module lsu_seq_ctrl
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              split,
    input  logic [DATA_W-1:0] mem_rdata,
    output seq_state_e        state,
    output logic [DATA_W-1:0] lo_buf
);
    // Advance through the beats of one access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (accept) state <= split ? ST_SECOND : ST_FINISH;
                ST_SECOND: state <= ST_FINISH;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Keep the first beat's read word during a two-beat access.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lo_buf <= '0;
        else if (state == ST_SECOND) lo_buf <= mem_rdata;
    end
endmodule

// File: rtl/lsu_lane_unit.sv
// Top of the load/store lane unit. It accepts one access at a time and
// issues one or two memory beats. A response is produced once the last beat's data is back.
// Assumes fixed one-cycle read latency and no memory back-pressure.
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    localparam int NB    = DATA_W / 8,
    localparam int OFFW  = $clog2(NB),
    localparam int WW    = ADDR_W - OFFW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [WW-1:0]     mem_word,
    output logic [NB-1:0]     mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    seq_state_e          state;
    logic [DATA_W-1:0]   lo_buf;
    logic                accept;
    logic                split_now;
    logic                lat_store, lat_uns, lat_split;
    acc_size_e           lat_size;
    logic [OFFW-1:0]     lat_off;
    logic [WW-1:0]       lat_word;
    logic [DATA_W-1:0]   lat_wdata;
    acc_size_e           cur_size;
    logic [OFFW-1:0]     cur_off;
    logic [DATA_W-1:0]   cur_wdata;
    logic [2*NB-1:0]     be_pair;
    logic [2*DATA_W-1:0] data_pair;
    logic [2*DATA_W-1:0] rd_pair;
    logic [DATA_W-1:0]   load_val;
    logic [OFFW+1:0]     span;

    // Handshake and split detection on the incoming request.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        span      = {2'b00, req_addr[OFFW-1:0]} + ((OFFW+2)'(1) << req_size);
        split_now = span > (OFFW+2)'(NB);
    end

    // Hold the accepted request for the later beats and the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_store <= 1'b0;
            lat_uns   <= 1'b0;
            lat_split <= 1'b0;
            lat_size  <= SZ_BYTE;
            lat_off   <= '0;
            lat_word  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_store <= req_store;
            lat_uns   <= req_unsigned;
            lat_split <= split_now;
            lat_size  <= acc_size_e'(req_size);
            lat_off   <= req_addr[OFFW-1:0];
            lat_word  <= req_addr[ADDR_W-1:OFFW];
            lat_wdata <= req_wdata;
        end
    end

    // The steering inputs come from the ports while idle and from the held copy otherwise.
    always_comb begin
        if (state == ST_IDLE) begin
            cur_size  = acc_size_e'(req_size);
            cur_off   = req_addr[OFFW-1:0];
            cur_wdata = req_wdata;
        end else begin
            cur_size  = lat_size;
            cur_off   = lat_off;
            cur_wdata = lat_wdata;
        end
    end

    lsu_store_steer #(.DATA_W(DATA_W)) steer_i (
        .size      (cur_size),
        .off       (cur_off),
        .wdata     (cur_wdata),
        .be_pair   (be_pair),
        .data_pair (data_pair)
    );

    lsu_seq_ctrl #(.DATA_W(DATA_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .split     (split_now),
        .mem_rdata (mem_rdata),
        .state     (state),
        .lo_buf    (lo_buf)
    );

    // Drive the memory beat: the first half of the pair while idle, the second half on beat two.
    always_comb begin
        if (state == ST_SECOND) begin
            mem_valid = 1'b1;
            mem_we    = lat_store;
            mem_word  = lat_word + WW'(1);
            mem_be    = be_pair[2*NB-1:NB];
            mem_wdata = data_pair[2*DATA_W-1:DATA_W];
        end else begin
            mem_valid = accept;
            mem_we    = req_store & accept;
            mem_word  = req_addr[ADDR_W-1:OFFW];
            mem_be    = accept ? be_pair[NB-1:0] : '0;
            mem_wdata = data_pair[DATA_W-1:0];
        end
    end

    // Join the read words; for a split access the buffered word is the low half.
    always_comb begin
        rd_pair = lat_split ? {mem_rdata, lo_buf} : {{DATA_W{1'b0}}, mem_rdata};
    end

    lsu_load_extract #(.DATA_W(DATA_W)) extract_i (
        .pair  (rd_pair),
        .off   (lat_off),
        .size  (lat_size),
        .uns   (lat_uns),
        .value (load_val)
    );

    // Present the response in the finish state.
    always_comb begin
        rsp_valid = (state == ST_FINISH);
        rsp_rdata = (rsp_valid && !lat_store) ? load_val : '0;
    end
endmodule

// File: rtl/lsu_lane_unit_chk.sv
// Port-level protocol checker for lsu_lane_unit, attached by bind.
// Assumes the requester honours req_ready.
module lsu_lane_unit_chk #(
    parameter int WW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_store,
    input logic          mem_valid,
    input logic          mem_we,
    input logic [WW-1:0] mem_word,
    input logic [7:0]    mem_be,
    input logic          rsp_valid,
    input logic [63:0]   rsp_rdata
);
    logic last_store;

    // Record whether the access in flight is a store.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_store <= 1'b0;
        else if (req_valid && req_ready) last_store <= req_store;
    end

    // R8
    busy_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R8
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R7
    second_beat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !req_ready) |-> ($past(mem_valid) && mem_word == $past(mem_word) + WW'(1)));

    // R6
    beat_has_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be != 8'h00));

    // R10
    store_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_store) |-> (rsp_rdata == 64'h0));

    // R10
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && req_ready && !req_store) |-> !mem_we);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.WW(WW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_store  (req_store),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_word   (mem_word),
    .mem_be     (mem_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/lsu_lane_unit_tb_top.sv
// Scoreboard bench: the driver predicts each result from a byte-level
// memory copy and queues it; the monitor compares every response.
module lsu_lane_unit_tb_top;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        mem_valid, mem_we;
    logic [AW-4:0] mem_word;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    typedef struct { logic [63:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    logic [63:0] mem [0:15];
    logic [7:0]  rb  [0:127];
    logic [63:0] rd_q;

    always #2 clk = ~clk;

    lsu_lane_unit #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_word(mem_word),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Memory model: byte-enabled write, one-cycle read.
    always @(posedge clk) begin
        if (mem_valid) begin
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[mem_word[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                rd_q <= mem[mem_word[3:0]];
            end
        end
    end
    assign mem_rdata = rd_q;

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1, 0, "R8 unexpected response");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_rdata, e.val, e.tag);
            end
        end
    end

    // Watchdog: an expired run is a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: predict, apply, check lanes, beats and response timing.
    task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                          input logic [AW-1:0] a, input logic [63:0] wd, input string tag);
        int nb, off, cyc;
        bit split;
        logic [15:0]  mask;
        logic [127:0] dpair;
        logic [63:0]  ev;
        exp_t e;
        nb    = 1 << sz;
        off   = int'(a[2:0]);
        split = (off + nb) > 8;
        mask  = 16'(((1 << nb) - 1) << off);
        dpair = '0;
        ev    = '0;
        for (int i = 0; i < nb; i++) begin
            dpair[8*(off+i) +: 8] = wd[8*i +: 8];
            ev[8*i +: 8] = rb[(int'(a) + i) % 128];
        end
        if (!st && sz != 2'd3 && !(uns) && ev[8*nb-1])
            for (int i = nb; i < 8; i++) ev[8*i +: 8] = 8'hFF;
        e.val = st ? 64'h0 : ev;
        e.tag = tag;
        exp_q.push_back(e);
        if (st)
            for (int i = 0; i < nb; i++) rb[(int'(a) + i) % 128] = wd[8*i +: 8];

        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        req_addr = a; req_wdata = wd;
        #1;
        check(mem_be, mask[7:0], {"R6 first-beat enables ", tag});
        check(mem_word, a[AW-1:3], {"R2 first-beat word ", tag});
        check(mem_we, st, {"R10 write flag ", tag});
        if (st) check(mem_wdata, dpair[63:0], {"R6 first-beat data ", tag});
        @(posedge clk);
        #1 req_valid = 1'b0;
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1 && split) begin
                check(mem_valid, 1, {"R7 second beat ", tag});
                check(mem_be, mask[15:8], {"R7 second-beat enables ", tag});
                check(mem_word, 13'(a[AW-1:3] + 1), {"R7 second-beat word ", tag});
                check(req_ready, 0, {"R8 busy ", tag});
                if (st) check(mem_wdata, dpair[127:64], {"R6 second-beat data ", tag});
            end
            if (rsp_valid || cyc > 8) break;
        end
        check(cyc, split ? 2 : 1, {"R8 latency ", tag});
        @(negedge clk);
        check(req_ready, 1, {"R8 ready after ", tag});
    endtask

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 128; i++) rb[i] = 8'(i * 37 + 5);
        for (int w = 0; w < 16; w++)
            for (int b = 0; b < 8; b++) mem[w][8*b +: 8] = rb[w*8 + b];
        rd_q = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, 1, "R1 ready at reset");
        check(mem_valid, 0, "R1 no beat at reset");
        check(rsp_valid, 0, "R1 no response at reset");

        access(1, 2'd3, 0, 16'h0008, 64'h8877_6655_4433_2211, "R5 aligned sd");
        access(0, 2'd3, 1, 16'h0008, 0, "R5 aligned ld unsigned flag");
        access(0, 2'd0, 0, 16'h000F, 0, "R3 lb negative");
        access(0, 2'd0, 1, 16'h000F, 0, "R4 lbu");
        access(0, 2'd0, 0, 16'h000A, 0, "R2 lb lane 2");
        access(1, 2'd1, 0, 16'h0017, 64'hFFFF_FFFF_FFFF_A5C3, "R7 sh split");
        access(0, 2'd1, 0, 16'h0017, 0, "R9 lh split signed");
        access(0, 2'd1, 1, 16'h0017, 0, "R4 lhu split");
        access(1, 2'd2, 0, 16'h001E, 64'h1234_5678_CAFE_F00D, "R7 sw split");
        access(0, 2'd2, 0, 16'h001E, 0, "R3 lw split");
        access(0, 2'd2, 1, 16'h001E, 0, "R4 lwu split");
        access(1, 2'd0, 0, 16'h0031, 64'hFFFF_FFFF_FFFF_FF7E, "R6 sb low byte only");
        access(0, 2'd3, 0, 16'h0030, 0, "R6 sb effect");
        access(1, 2'd3, 0, 16'h002B, 64'h0102_0304_0506_0708, "R7 sd split");
        access(0, 2'd3, 0, 16'h002B, 0, "R9 ld split");
        access(0, 2'd3, 0, 16'h007D, 0, "R9 ld wrap");
        access(0, 2'd2, 0, 16'h0004, 0, "R3 lw upper half");

        lcg = 32'h1357_9BDF;
        for (int n = 0; n < 80; n++) begin
            bit st;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            st = lcg[31];
            access(st, lcg[9:8], lcg[10], {9'd0, lcg[22:16]},
                   {lcg, ~lcg ^ 32'h5A5A_A5A5}, st ? "R6 mixed store" : "R9 mixed load");
        end

        repeat (4) @(negedge clk);
        check(exp_q.size(), 0, "R8 all responses seen");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule